// File: doc/BRIEF.md
# SEC-DED Hamming Codec for Byte Data

This block protects an 8-bit data byte with a 13-bit code word. The code word uses a single-error-correcting Hamming code and adds one overall parity bit, so it can also detect double errors. The encoder is purely combinational. It places the data bits and check bits by position number, so that the syndrome seen on a read names the failing position directly.

The decoder takes a stored code word together with a valid strobe. It recomputes the check equations to form a 4-bit syndrome and evaluates the overall parity of the word. From these two results it classifies the word as one of four cases:

- clean;
- a single error it can repair;
- an error in the overall parity bit alone;
- an uncorrectable word.

Every decoder output is held in registers and appears one clock after the strobe. Between strobes the outputs keep their last values.

Top module: `secded_codec`

## Requirements
- R1: Code word bit p carries Hamming position p for p = 1..12, and bit 0 carries the overall parity. Check bits sit at positions 1, 2, 4 and 8. Data bits enc_data_i[0]..enc_data_i[7] sit at positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. For data 8'h39 the code word is 13'h069F.
- R2: Naming data bit k+1 as Dk+1 = enc_data_i[k], the check bits obey these equations: position 1 = D1^D2^D4^D5^D7, position 2 = D1^D3^D4^D6^D7, position 4 = D2^D3^D4^D8, position 8 = D5^D6^D7^D8.
- R3: Bit 0 of every encoder output makes the total count of ones over all 13 bits even.
- R4: Suppose a word has a zero syndrome and even overall parity. The decoder then returns the data bits of the word unchanged, with both flags low.
- R5: Suppose a word has odd overall parity and a syndrome s in 1..12. The decoder then inverts position s before it extracts the data, raises dec_fixed_o and keeps dec_fatal_o low. For example, flipping position 6 of 13'h069F gives syndrome 6, and the decoder returns 8'h39.
- R6: Suppose a word has odd overall parity and a zero syndrome. The decoder then treats the overall parity bit as the faulty bit: the data pass through unchanged, dec_fixed_o is raised and dec_fatal_o stays low.
- R7: Suppose a word has a nonzero syndrome and even overall parity, as any two flipped bits produce. The decoder then raises dec_fatal_o, keeps dec_fixed_o low, and returns the data bits of the word without changing them.
- R8: Suppose a word has odd overall parity and a syndrome of 13, 14 or 15. The decoder reports it as uncorrectable, exactly as in R7.
- R9: dec_valid_o is dec_valid_i delayed by one clock. When dec_valid_i is low, the decoder data and flag outputs hold their previous values.
- R10: While rst_n is low, dec_valid_o, dec_data_o, dec_fixed_o and dec_fatal_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 8 | Data byte to encode |
| enc_code_o | output | 13 | Code word; bit 0 is overall parity, bit p is position p |
| dec_valid_i | input | 1 | Strobe qualifying dec_code_i |
| dec_code_i | input | 13 | Stored code word to check |
| dec_valid_o | output | 1 | Decoder result valid, one clock after the strobe |
| dec_data_o | output | 8 | Corrected or passed-through data |
| dec_fixed_o | output | 1 | A single error was repaired |
| dec_fatal_o | output | 1 | The word is uncorrectable |

## Verification
The encoder has no registers. The bench therefore applies each data byte and reads enc_code_o after a short settling delay in the same cycle.

The decoder results are due at the first rising edge after a strobe. The bench drives each strobed word on a falling edge and compares dec_valid_o, dec_data_o and both flags at the next falling edge. Because the comparison comes half a period after the capturing edge, it cannot race that edge.

To check the hold behaviour, the bench drops the strobe and applies a garbage word. At the following falling edge it confirms that dec_valid_o is low and that the data and flags have not changed.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_FIX   = 2'd1,
    CLS_PAR   = 2'd2,
    CLS_BAD   = 2'd3
  } err_cls_e;

  // Number of check bits needed so that 2^r covers data + checks + 1.
  function automatic int chk_width(input int dw);
    int res;
    res = 0;
    for (int r = 1; r < 16; r++) begin
      if (res == 0 && (1 << r) >= dw + r + 1) res = r;
    end
    return res;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Hamming position of data bit k: the k-th position that is not a power of two.
  function automatic int data_pos(input int k);
    int res;
    int cnt;
    res = 0;
    cnt = 0;
    for (int p = 1; p < 64; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == k) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Data bits that feed check bit i.
  function automatic logic [63:0] data_mask(input int i, input int dw);
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < dw; k++) m[k] = ((data_pos(k) >> i) & 1) != 0;
    return m;
  endfunction

  // Code word positions (1..63) covered by syndrome bit i; bit 0 left clear.
  function automatic logic [63:0] pos_mask(input int i);
    logic [63:0] m;
    m = '0;
    for (int p = 1; p < 64; p++) m[p] = ((p >> i) & 1) != 0;
    return m;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = chk_width(DATA_W),
  localparam int CODE_N = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_N:0]   code_o
);

  logic [CODE_N:1] body;
  logic [CHK_W-1:0] chk;

  for (genvar k = 0; k < DATA_W; k++) begin : g_data
    localparam int P = data_pos(k);
    assign body[P] = data_i[k];
  end

  for (genvar i = 0; i < CHK_W; i++) begin : g_chk
    localparam logic [63:0] M = data_mask(i, DATA_W);
    assign chk[i]          = ^(data_i & M[DATA_W-1:0]);
    assign body[1 << i]    = chk[i];
  end

  assign code_o = {body, ^body};

endmodule

// File: rtl/secded_syn.sv
module secded_syn
  import secded_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = chk_width(DATA_W),
  localparam int CODE_N = DATA_W + CHK_W
) (
  input  logic [CODE_N:0]  code_i,
  output logic [CHK_W-1:0] syn_o,
  output logic             par_fail_o
);

  // Each syndrome bit folds the stored check bit with its recomputed value.
  for (genvar i = 0; i < CHK_W; i++) begin : g_syn
    localparam logic [63:0] M = pos_mask(i);
    assign syn_o[i] = ^(code_i & M[CODE_N:0]);
  end

  assign par_fail_o = ^code_i;

endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = chk_width(DATA_W),
  localparam int CODE_N = DATA_W + CHK_W
) (
  input  logic [CODE_N:0]   code_i,
  input  logic [CHK_W-1:0]  syn_i,
  input  logic              par_fail_i,
  output logic [DATA_W-1:0] data_o,
  output err_cls_e          cls_o
);

  logic [CODE_N:0] flip;
  logic [CODE_N:0] fixed;

  always_comb begin
    if (!par_fail_i) begin
      cls_o = (syn_i == '0) ? CLS_CLEAN : CLS_BAD;
    end else if (syn_i == '0) begin
      cls_o = CLS_PAR;
    end else if (int'(syn_i) <= CODE_N) begin
      cls_o = CLS_FIX;
    end else begin
      cls_o = CLS_BAD;
    end
  end

  always_comb begin
    flip = '0;
    if (cls_o == CLS_FIX) flip = {{CODE_N{1'b0}}, 1'b1} << syn_i;
  end

  assign fixed = code_i ^ flip;

  for (genvar k = 0; k < DATA_W; k++) begin : g_ext
    localparam int P = data_pos(k);
    assign data_o[k] = fixed[P];
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = chk_width(DATA_W),
  localparam int CODE_N = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CODE_N:0]   enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_N:0]   dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_fixed_o,
  output logic              dec_fatal_o
);

  logic [CHK_W-1:0]  syn;
  logic              par_fail;
  logic [DATA_W-1:0] fix_data;
  err_cls_e          cls;

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic              fixed_d, fixed_q;
  logic              fatal_d, fatal_q;

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_o)
  );

  secded_syn #(.DATA_W(DATA_W)) u_syn (
    .code_i     (dec_code_i),
    .syn_o      (syn),
    .par_fail_o (par_fail)
  );

  secded_fix #(.DATA_W(DATA_W)) u_fix (
    .code_i     (dec_code_i),
    .syn_i      (syn),
    .par_fail_i (par_fail),
    .data_o     (fix_data),
    .cls_o      (cls)
  );

  // Next-state: result registers load only under the input strobe.
  always_comb begin
    valid_d = dec_valid_i;
    data_d  = data_q;
    fixed_d = fixed_q;
    fatal_d = fatal_q;
    if (dec_valid_i) begin
      data_d  = fix_data;
      fixed_d = (cls == CLS_FIX) || (cls == CLS_PAR);
      fatal_d = (cls == CLS_BAD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      fixed_q <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      fixed_q <= fixed_d;
      fatal_q <= fatal_d;
    end
  end

  assign dec_valid_o = valid_q;
  assign dec_data_o  = data_q;
  assign dec_fixed_o = fixed_q;
  assign dec_fatal_o = fatal_q;

  AST_ENC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (^enc_code_o) == 1'b0); // R3
  AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && syn == '0 && !par_fail) |=> (!dec_fixed_o && !dec_fatal_o)); // R4
  AST_PAR_ONLY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && syn == '0 && par_fail) |=> (dec_fixed_o && !dec_fatal_o)); // R6
  AST_DOUBLE_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && syn != '0 && !par_fail) |=> (dec_fatal_o && !dec_fixed_o)); // R7
  AST_HIGH_SYN_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && par_fail && int'(syn) > CODE_N) |=> dec_fatal_o); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_fixed_o && dec_fatal_o)); // R7
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> dec_valid_o); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> !dec_valid_o); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_fixed_o) && $stable(dec_fatal_o))); // R9

endmodule

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb;

  logic        clk;
  logic        rst_n;
  logic [7:0]  enc_data_i;
  logic [12:0] enc_code_o;
  logic        dec_valid_i;
  logic [12:0] dec_code_i;
  logic        dec_valid_o;
  logic [7:0]  dec_data_o;
  logic        dec_fixed_o;
  logic        dec_fatal_o;

  int checks = 0;
  int bad    = 0;

  secded_codec u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_data_i  (enc_data_i),
    .enc_code_o  (enc_code_o),
    .dec_valid_i (dec_valid_i),
    .dec_code_i  (dec_code_i),
    .dec_valid_o (dec_valid_o),
    .dec_data_o  (dec_data_o),
    .dec_fixed_o (dec_fixed_o),
    .dec_fatal_o (dec_fatal_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [12:0] ref_enc(input logic [7:0] d);
    logic [12:0] w;
    w[3]  = d[0]; w[5]  = d[1]; w[6]  = d[2]; w[7]  = d[3];
    w[9]  = d[4]; w[10] = d[5]; w[11] = d[6]; w[12] = d[7];
    w[1]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    w[2]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    w[4]  = d[1] ^ d[2] ^ d[3] ^ d[7];
    w[8]  = d[4] ^ d[5] ^ d[6] ^ d[7];
    w[0]  = ^w[12:1];
    return w;
  endfunction

  function automatic logic [7:0] ref_ext(input logic [12:0] w);
    return {w[12], w[11], w[10], w[9], w[7], w[6], w[5], w[3]};
  endfunction

  // Expected decode: returns {data, fixed, fatal}.
  function automatic logic [9:0] ref_dec(input logic [12:0] w);
    logic [3:0]  s;
    logic        pf;
    logic [12:0] v;
    v = w;
    s[0] = w[1] ^ w[3] ^ w[5] ^ w[7] ^ w[9] ^ w[11];
    s[1] = w[2] ^ w[3] ^ w[6] ^ w[7] ^ w[10] ^ w[11];
    s[2] = w[4] ^ w[5] ^ w[6] ^ w[7] ^ w[12];
    s[3] = w[8] ^ w[9] ^ w[10] ^ w[11] ^ w[12];
    pf   = ^w;
    if (!pf && s == 4'd0) return {ref_ext(w), 2'b00};        // R4
    if (!pf)              return {ref_ext(w), 2'b01};        // R7
    if (s == 4'd0)        return {ref_ext(w), 2'b10};        // R6
    if (s > 4'd12)        return {ref_ext(w), 2'b01};        // R8
    v[s] = ~v[s];                                            // R5
    return {ref_ext(v), 2'b10};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one strobed word at a falling edge, compare at the next falling edge.
  task automatic dec_one(input string req, input logic [12:0] w);
    logic [9:0] e;
    e = ref_dec(w);
    dec_valid_i = 1'b1;
    dec_code_i  = w;
    @(negedge clk);
    check(req, {dec_valid_o, dec_data_o, dec_fixed_o, dec_fatal_o}, {1'b1, e});
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [10:0] last;
    rst_n       = 1'b0;
    enc_data_i  = 8'h00;
    dec_valid_i = 1'b0;
    dec_code_i  = 13'h0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {dec_valid_o, dec_data_o, dec_fixed_o, dec_fatal_o}, 11'h000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: known example
    enc_data_i = 8'h39;
    #1;
    check("R1", {1'b0, 10'(0)} | 11'(enc_code_o), 11'(13'h069F) & 11'h7FF);
    check("R2", {7'd0, enc_code_o[8], enc_code_o[4], enc_code_o[2], enc_code_o[1]}, 11'b0111);

    // R1 R2 R3: encoder sweep
    for (int d = 0; d < 256; d++) begin
      enc_data_i = 8'(d);
      #1;
      checks++;
      if (enc_code_o !== ref_enc(8'(d)) || (^enc_code_o) !== 1'b0) begin
        bad++;
        $display("FAIL R2/R3 actual=%h expected=%h", enc_code_o, ref_enc(8'(d)));
      end
    end
    @(negedge clk);

    // R5: flip position 6 of the example
    dec_one("R5", 13'h069F ^ 13'h0040);
    check("R5", 11'(dec_data_o), 11'h039);

    // Decoder sweep
    for (int d = 0; d < 256; d++) begin
      logic [12:0] w;
      w = ref_enc(8'(d));
      dec_one("R4", w);
      for (int i = 0; i < 13; i++) begin
        if (i == 0) dec_one("R6", w ^ 13'h0001);
        else        dec_one("R5", w ^ (13'h0001 << i));
      end
      for (int i = 0; i < 13; i++) begin
        for (int j = i + 1; j < 13; j++) begin
          dec_one("R7", w ^ (13'h0001 << i) ^ (13'h0001 << j));
        end
      end
      dec_one("R8", w ^ 13'h0112); // positions 1,4,8 -> syndrome 13
      dec_one("R8", w ^ 13'h0114); // positions 2,4,8 -> syndrome 14
    end

    // R9: hold with strobe low
    dec_one("R9", ref_enc(8'hA5) ^ 13'h0006);
    last = {1'b1, dec_data_o, dec_fixed_o, dec_fatal_o};
    dec_valid_i = 1'b0;
    dec_code_i  = 13'h1ABC;
    @(negedge clk);
    check("R9", {dec_valid_o, dec_data_o, dec_fixed_o, dec_fatal_o}, {1'b0, last[9:0]});
    @(negedge clk);
    check("R9", {dec_valid_o, dec_data_o, dec_fixed_o, dec_fatal_o}, {1'b0, last[9:0]});

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule